// File: doc/BRIEF.md
# Multi-Hart Machine Timer Compare Unit

This block provides one free-running 64-bit real-time counter that a group of harts shares. Each hart also has its own 64-bit compare register and one timer interrupt line. The counter advances by one on every clock cycle in which the timebase tick input is high. A hart's interrupt stays raised for as long as its compare value is at or below the counter.

Software reaches the counter and the compare array through a simple single-cycle register bus that accepts 4-byte and 8-byte little-endian accesses. The counter window and the compare window each start at a base address set by a parameter. A software write to the counter, either to one 32-bit half or to the whole word, is compared against every hart's threshold on the next cycle. A first-hart parameter sets the global hart number of the lowest interrupt bit, so several of these units can cover one larger hart range.

Top module: `mtimer_cmp_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the counter reads zero, every compare register reads zero, `ready` is low and every `irq` bit is low.
- R2: The counter increases by exactly one on each cycle in which `tick_en` is high and no counter write occurs. It holds its value otherwise. A write to a compare register does not stop the increment.
- R3: Each interrupt bit is high exactly when its hart's compare value is less than or equal to the counter, compared as unsigned 64-bit numbers. The bit is registered, so it reflects the state of the previous cycle.
- R4: Compare registers occupy 8 bytes per hart starting at `CMP_BASE`. Slot s = (addr − `CMP_BASE`) >> 3 is mapped when s < `NUM_HARTS`, and it drives `irq[FIRST_HART + s]`.
- R5: The access size is encoded by `size`: 0 means 4 bytes and 1 means 8 bytes. At word offset 0 (addr[2:0] = 0), a 4-byte access reaches bits [31:0] and an 8-byte access reaches all 64 bits. At offset 4, a 4-byte access reaches bits [63:32]. Read data for a 4-byte access, and for any read at offset 4, is returned in `rdata[31:0]` with the upper bits zero.
- R6: A 4-byte write to one half of a compare register leaves the other half unchanged.
- R7: An 8-byte write at offset 4 of a compare register or of the counter changes nothing.
- R8: The counter sits at `CNT_BASE` with the same half layout. A write replaces only the addressed portion, and all interrupts reflect the new value one cycle later.
- R9: When a counter write and a tick fall in the same cycle, the written value is stored and the tick is lost.
- R10: Reads of unmapped addresses return zero and writes to them change no register. Unmapped means outside both windows, or an offset other than 0 or 4. A write one slot past the last compare register does not alias onto slot 0.
- R11: `ready` is high in the cycle after each cycle in which `req` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase tick, one counter increment per high cycle |
| req | input | 1 | Bus access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 1 | 0 = 4-byte access, 1 = 8-byte access |
| addr | input | ADDR_W | Byte address |
| wdata | input | 64 | Write data, low lane for 4-byte writes |
| rdata | output | 64 | Registered read data |
| ready | output | 1 | Access completion, one cycle after `req` |
| irq | output | NUM_HARTS | Timer interrupt per hart, bit index = global hart number |

## Verification
A software write to the counter and a timebase tick can occur in the same clock edge. The write must win, while a compare write on the same edge must not hold back the tick. The bench holds `tick_en` high across a full 64-bit counter write and reads back the exact written value. It then holds the tick high across a compare write and expects the counter to have moved by exactly one. Interrupt timing around counter writes is checked both on the cycle right after the write, where the old level is expected, and one cycle later, where the new level is expected.

// File: rtl/mtcmp_pkg.sv
package mtcmp_pkg;

  localparam int WORD_W = 64;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CNT  = 2'd1,
    TGT_CMP  = 2'd2
  } tgt_e;

  typedef struct packed {
    logic lo;
    logic hi;
  } wr_mask_t;

  // Merge bus write data into a stored word. A lone upper-half write
  // takes its data from the low lane of the bus.
  function automatic logic [WORD_W-1:0] merge_word(
    input logic [WORD_W-1:0] old_w,
    input logic [WORD_W-1:0] wd,
    input wr_mask_t          m
  );
    logic [WORD_W-1:0] r;
    r = old_w;
    if (m.lo) r[HALF_W-1:0] = wd[HALF_W-1:0];
    if (m.hi) r[WORD_W-1:HALF_W] = m.lo ? wd[WORD_W-1:HALF_W] : wd[HALF_W-1:0];
    return r;
  endfunction

endpackage

// File: rtl/mtcmp_decode.sv
module mtcmp_decode
  import mtcmp_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                NUM_HARTS = 4,
  parameter int                SLOT_W    = 2,
  parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
  parameter logic [ADDR_W-1:0] CNT_BASE  = '0
) (
  input  logic              req,
  input  logic              we,
  input  logic              size,
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [SLOT_W-1:0] slot,
  output logic              hi_off,
  output wr_mask_t          wm
);

  localparam int CMP_SPAN = NUM_HARTS * 8;

  logic [ADDR_W-1:0] cmp_off;
  logic              in_cmp;
  logic              in_cnt;
  logic              lo_off;

  always_comb begin
    cmp_off = addr - CMP_BASE;
    in_cmp  = (addr >= CMP_BASE) && (32'(cmp_off) < 32'(CMP_SPAN));
    in_cnt  = (addr[ADDR_W-1:3] == CNT_BASE[ADDR_W-1:3]);
    lo_off  = (addr[2:0] == 3'd0);
    hi_off  = (addr[2:0] == 3'd4);
    slot    = cmp_off[3 +: SLOT_W];

    tgt = TGT_NONE;
    if (lo_off || hi_off) begin
      if (in_cnt)      tgt = TGT_CNT;
      else if (in_cmp) tgt = TGT_CMP;
    end

    wm = '0;
    if (req && we && (tgt != TGT_NONE)) begin
      if (lo_off) begin
        wm.lo = 1'b1;
        wm.hi = size;
      end else if (!size) begin
        wm.hi = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mtcmp_counter.sv
module mtcmp_counter
  import mtcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  wr_mask_t          wm,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wm.lo || wm.hi) begin
      cnt <= merge_word(cnt, wdata, wm);
    end else if (tick_en) begin
      cnt <= cnt + WORD_W'(1);
    end
  end

endmodule

// File: rtl/mtcmp_bank.sv
module mtcmp_bank
  import mtcmp_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int SLOT_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  wr_mask_t                    wm,
  input  logic [SLOT_W-1:0]           slot,
  input  logic [WORD_W-1:0]           wdata,
  output logic [NUM_HARTS*WORD_W-1:0] cmp_flat
);

  logic [WORD_W-1:0] cmp_q [NUM_HARTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_HARTS; i++) cmp_q[i] <= '0;
    end else if (wm.lo || wm.hi) begin
      for (int i = 0; i < NUM_HARTS; i++) begin
        if (slot == SLOT_W'(i)) cmp_q[i] <= merge_word(cmp_q[i], wdata, wm);
      end
    end
  end

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_flat
    assign cmp_flat[g*WORD_W +: WORD_W] = cmp_q[g];
  end

endmodule

// File: rtl/mtcmp_irq.sv
module mtcmp_irq
  import mtcmp_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [WORD_W-1:0]           cnt,
  input  logic [NUM_HARTS*WORD_W-1:0] cmp_flat,
  output logic [NUM_HARTS-1:0]        irq
);

  logic [NUM_HARTS-1:0] hit;

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_cmp
    assign hit[g] = (cmp_flat[g*WORD_W +: WORD_W] <= cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= hit;
  end

endmodule

// File: rtl/mtimer_cmp_unit.sv
module mtimer_cmp_unit
  import mtcmp_pkg::*;
#(
  parameter int                NUM_HARTS  = 4,
  parameter int                FIRST_HART = 0,
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] CMP_BASE   = 16'h4000,
  parameter logic [ADDR_W-1:0] CNT_BASE   = 16'hBFF8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 tick_en,
  input  logic                                 req,
  input  logic                                 we,
  input  logic                                 size,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [63:0]                          wdata,
  output logic [63:0]                          rdata,
  output logic                                 ready,
  output logic [FIRST_HART+NUM_HARTS-1:FIRST_HART] irq
);

  localparam int SLOT_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  tgt_e                        tgt;
  logic [SLOT_W-1:0]           slot;
  logic                        hi_off;
  wr_mask_t                    dec_wm;
  wr_mask_t                    cnt_wm;
  wr_mask_t                    cmp_wm;
  logic                        cnt_wr_any;
  logic [WORD_W-1:0]           cnt_q;
  logic [NUM_HARTS*WORD_W-1:0] cmp_flat;
  logic [NUM_HARTS-1:0]        irq_int;
  logic [WORD_W-1:0]           sel_word;
  logic [WORD_W-1:0]           rd_next;

  mtcmp_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_HARTS (NUM_HARTS),
    .SLOT_W    (SLOT_W),
    .CMP_BASE  (CMP_BASE),
    .CNT_BASE  (CNT_BASE)
  ) u_dec (
    .req    (req),
    .we     (we),
    .size   (size),
    .addr   (addr),
    .tgt    (tgt),
    .slot   (slot),
    .hi_off (hi_off),
    .wm     (dec_wm)
  );

  assign cnt_wm     = (tgt == TGT_CNT) ? dec_wm : '0;
  assign cmp_wm     = (tgt == TGT_CMP) ? dec_wm : '0;
  assign cnt_wr_any = cnt_wm.lo | cnt_wm.hi;

  mtcmp_counter u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .wm      (cnt_wm),
    .wdata   (wdata),
    .cnt     (cnt_q)
  );

  mtcmp_bank #(
    .NUM_HARTS (NUM_HARTS),
    .SLOT_W    (SLOT_W)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wm       (cmp_wm),
    .slot     (slot),
    .wdata    (wdata),
    .cmp_flat (cmp_flat)
  );

  mtcmp_irq #(
    .NUM_HARTS (NUM_HARTS)
  ) u_irq (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt_q),
    .cmp_flat (cmp_flat),
    .irq      (irq_int)
  );

  assign irq = irq_int;

  // Read path: select the addressed word, then the addressed half.
  always_comb begin
    sel_word = '0;
    if (tgt == TGT_CNT) begin
      sel_word = cnt_q;
    end else if (tgt == TGT_CMP) begin
      for (int i = 0; i < NUM_HARTS; i++) begin
        if (slot == SLOT_W'(i)) sel_word = cmp_flat[i*WORD_W +: WORD_W];
      end
    end

    if (hi_off)    rd_next = {{HALF_W{1'b0}}, sel_word[WORD_W-1:HALF_W]};
    else if (size) rd_next = sel_word;
    else           rd_next = {{HALF_W{1'b0}}, sel_word[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      rdata <= '0;
    end else begin
      ready <= req;
      rdata <= (req && !we) ? rd_next : '0;
    end
  end

endmodule

// File: rtl/mtcmp_chk.sv
module mtcmp_chk #(
  parameter int                NUM_HARTS = 4,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CNT_BASE  = '0
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     tick_en,
  input logic                     req,
  input logic                     we,
  input logic                     size,
  input logic [ADDR_W-1:0]        addr,
  input logic [63:0]              wdata,
  input logic                     ready,
  input logic                     cnt_wr,
  input logic [63:0]              cnt,
  input logic [NUM_HARTS*64-1:0]  cmp_flat,
  input logic [NUM_HARTS-1:0]     irq
);

  logic cnt_win;
  assign cnt_win = req && we && (addr[ADDR_W-1:3] == CNT_BASE[ADDR_W-1:3]);

  // R2
  cnt_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !cnt_wr) |=> (cnt == $past(cnt) + 64'd1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !cnt_wr) |=> $stable(cnt));

  // R8
  cnt_full_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_win && size && addr[2:0] == 3'd0) |=> (cnt == $past(wdata)));

  // R7
  cnt_hi64_ign_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_win && size && addr[2:0] == 3'd4) |-> !cnt_wr);

  // R11
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> ready);

  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> !ready);

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_irq
    // R3
    irq_track_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> (irq[g] == ($past(cmp_flat[g*64 +: 64]) <= $past(cnt))));
  end

endmodule

bind mtimer_cmp_unit mtcmp_chk #(
  .NUM_HARTS (NUM_HARTS),
  .ADDR_W    (ADDR_W),
  .CNT_BASE  (CNT_BASE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_en  (tick_en),
  .req      (req),
  .we       (we),
  .size     (size),
  .addr     (addr),
  .wdata    (wdata),
  .ready    (ready),
  .cnt_wr   (cnt_wr_any),
  .cnt      (cnt_q),
  .cmp_flat (cmp_flat),
  .irq      (irq_int)
);

// File: tb/mtimer_cmp_unit_tb.sv
module mtimer_cmp_unit_tb;

  localparam int          NH   = 4;
  localparam int          FH   = 4;
  localparam logic [15:0] CMPB = 16'h4000;
  localparam logic [15:0] CNTB = 16'hBFF8;

  typedef struct packed {
    logic        we;
    logic        sz;
    logic [15:0] addr;
    logic [63:0] wd;
    logic [63:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'hBFF8, 64'h0,                   64'h0,                   4'd1},  // R1
    '{1'b1, 1'b1, 16'hBFF8, 64'h0000_0001_0000_0010, 64'h0,                   4'd8},  // R8
    '{1'b0, 1'b1, 16'hBFF8, 64'h0,                   64'h0000_0001_0000_0010, 4'd8},
    '{1'b1, 1'b0, 16'hBFFC, 64'h0000_0000_0000_0002, 64'h0,                   4'd8},
    '{1'b0, 1'b0, 16'hBFFC, 64'h0,                   64'h0000_0000_0000_0002, 4'd5},  // R5
    '{1'b0, 1'b1, 16'hBFF8, 64'h0,                   64'h0000_0002_0000_0010, 4'd8},
    '{1'b1, 1'b0, 16'hBFF8, 64'hABCD_0000_FFFF_FFF0, 64'h0,                   4'd8},
    '{1'b0, 1'b1, 16'hBFF8, 64'h0,                   64'h0000_0002_FFFF_FFF0, 4'd8},
    '{1'b1, 1'b1, 16'hBFFC, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   4'd7},  // R7
    '{1'b0, 1'b1, 16'hBFF8, 64'h0,                   64'h0000_0002_FFFF_FFF0, 4'd7},
    '{1'b1, 1'b1, 16'h4008, 64'h1122_3344_5566_7788, 64'h0,                   4'd4},  // R4
    '{1'b1, 1'b0, 16'h4008, 64'h0000_0000_AABB_CCDD, 64'h0,                   4'd6},  // R6
    '{1'b0, 1'b1, 16'h4008, 64'h0,                   64'h1122_3344_AABB_CCDD, 4'd6},
    '{1'b1, 1'b0, 16'h400C, 64'h0000_0000_0000_0099, 64'h0,                   4'd6},
    '{1'b0, 1'b0, 16'h400C, 64'h0,                   64'h0000_0000_0000_0099, 4'd5},
    '{1'b0, 1'b0, 16'h4008, 64'h0,                   64'h0000_0000_AABB_CCDD, 4'd5},
    '{1'b0, 1'b1, 16'h4008, 64'h0,                   64'h0000_0099_AABB_CCDD, 4'd6},
    '{1'b0, 1'b1, 16'h400C, 64'h0,                   64'h0000_0000_0000_0099, 4'd5},
    '{1'b1, 1'b1, 16'h4014, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   4'd7},
    '{1'b0, 1'b1, 16'h4010, 64'h0,                   64'h0,                   4'd7},
    '{1'b1, 1'b1, 16'h4020, 64'h0000_0000_0000_DEAD, 64'h0,                   4'd10}, // R10
    '{1'b0, 1'b1, 16'h4000, 64'h0,                   64'h0,                   4'd10},
    '{1'b0, 1'b1, 16'h4020, 64'h0,                   64'h0,                   4'd10},
    '{1'b0, 1'b0, 16'hBFFA, 64'h0,                   64'h0,                   4'd10},
    '{1'b1, 1'b0, 16'h4001, 64'h0000_0000_0000_FFFF, 64'h0,                   4'd10},
    '{1'b0, 1'b1, 16'h4000, 64'h0,                   64'h0,                   4'd10},
    '{1'b0, 1'b1, 16'h4018, 64'h0,                   64'h0,                   4'd4}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick_en = 1'b0;
  logic              req = 1'b0;
  logic              we = 1'b0;
  logic              size = 1'b0;
  logic [15:0]       addr = '0;
  logic [63:0]       wdata = '0;
  logic [63:0]       rdata;
  logic              ready;
  logic [FH+NH-1:FH] irq;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  mtimer_cmp_unit #(
    .NUM_HARTS  (NH),
    .FIRST_HART (FH),
    .ADDR_W     (16),
    .CMP_BASE   (CMPB),
    .CNT_BASE   (CNTB)
  ) u_dut (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .req     (req),
    .we      (we),
    .size    (size),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .ready   (ready),
    .irq     (irq)
  );

  task automatic check(input string rq, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the access.
  task automatic bus_op(input logic w, input logic sz, input logic [15:0] a,
                        input logic [63:0] d, output logic [63:0] rd);
    req = 1'b1; we = w; size = sz; addr = a; wdata = d;
    @(negedge clk);
    rd = rdata;
    check("R11 ready", {63'b0, ready}, 64'd1);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [63:0] rd;
    @(negedge clk);
    @(negedge clk);
    check("R1 irq in reset", {60'b0, irq}, 64'd0);
    check("R1 ready in reset", {63'b0, ready}, 64'd0);
    check("R1 rdata in reset", rdata, 64'd0);
    rst = 1'b0;

    // table walk, tick held low
    for (int i = 0; i < NV; i++) begin
      bus_op(VECS[i].we, VECS[i].sz, VECS[i].addr, VECS[i].wd, rd);
      if (!VECS[i].we) check($sformatf("R%0d vec %0d", VECS[i].rq, i), rd, VECS[i].exp);
    end

    // R3 R4: cnt=0x2_FFFFFFF0, cmp = {0, 0x99_AABBCCDD, 0, 0}
    idle(1);
    check("R3 initial levels", {60'b0, irq}, 64'b1101);
    check("R11 idle ready", {63'b0, ready}, 64'd0);

    bus_op(1'b1, 1'b1, 16'h4018, 64'h0000_0002_FFFF_FFF0, rd);
    bus_op(1'b1, 1'b1, 16'h4000, 64'h0000_0002_FFFF_FFF1, rd);
    idle(1);
    check("R3 equal and above", {60'b0, irq}, 64'b1100);

    // R8: counter write re-evaluates interrupts one cycle later
    bus_op(1'b1, 1'b1, 16'hBFF8, 64'h0000_0002_FFFF_FFF1, rd);
    check("R3 irq registered", {60'b0, irq}, 64'b1100);
    idle(1);
    check("R8 reeval full write", {60'b0, irq}, 64'b1101);
    bus_op(1'b1, 1'b0, 16'hBFF8, 64'h0, rd);
    idle(1);
    check("R8 reeval low write", {60'b0, irq}, 64'b0100);

    // R2: ticking across a compare threshold
    bus_op(1'b1, 1'b1, 16'hBFF8, 64'd100, rd);
    bus_op(1'b1, 1'b1, 16'h4010, 64'd110, rd);
    idle(1);
    check("R3 none pending", {60'b0, irq}, 64'b0000);
    tick_en = 1'b1;
    idle(9);
    tick_en = 1'b0;
    idle(1);
    check("R2 below threshold", {60'b0, irq}, 64'b0000);
    tick_en = 1'b1;
    idle(1);
    tick_en = 1'b0;
    idle(1);
    check("R2 threshold reached", {60'b0, irq}, 64'b0100);
    bus_op(1'b0, 1'b1, 16'hBFF8, 64'h0, rd);
    check("R2 tick count", rd, 64'd110);

    // R9: write and tick in the same cycle
    tick_en = 1'b1;
    bus_op(1'b1, 1'b1, 16'hBFF8, 64'd500, rd);
    tick_en = 1'b0;
    bus_op(1'b0, 1'b1, 16'hBFF8, 64'h0, rd);
    check("R9 write beats tick", rd, 64'd500);
    tick_en = 1'b1;
    bus_op(1'b1, 1'b0, 16'h4008, 64'h0, rd);
    tick_en = 1'b0;
    bus_op(1'b0, 1'b1, 16'hBFF8, 64'h0, rd);
    check("R2 tick during compare write", rd, 64'd501);

    // R1: reset in the middle of operation
    rst = 1'b1;
    idle(1);
    check("R1 irq after reset", {60'b0, irq}, 64'd0);
    idle(1);
    rst = 1'b0;
    bus_op(1'b0, 1'b1, 16'hBFF8, 64'h0, rd);
    check("R1 counter cleared", rd, 64'd0);
    bus_op(1'b0, 1'b1, 16'h4010, 64'h0, rd);
    check("R1 compare cleared", rd, 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule